// File: doc/BRIEF.md
# Dual-Port Collision Arbiter

This block sits between two independent requesters and a shared two-port word memory. When both sides select the same word at the same time, it grants one side and holds the other off. The losing side sees its BUSY line pulled low, and its write does not reach the memory. Each side supplies an active-low select, an active-low write strobe, active-low upper and lower byte enables and a 13-bit address. The block returns an active-low BUSY, a write-block flag and two byte-lane write strobes for each side. The memory applies a write only through those strobes.

A role strap picks one of two behaviours. In master role the block arbitrates itself. Timing comparisons are made by clock cycle. If both sides were already selected in the previous cycle and their addresses come to match, the side whose address did not move wins. Otherwise the side that was selected in the previous cycle wins. Any tie goes to the left side. A grant lasts until the owner drops its select or changes its address, or until the match ends. In slave role the block does not arbitrate. The BUSY inputs from an external master are passed through, and a low BUSY blocks that side's writes. This lets several blocks widen the data path under a single arbiter.

The arbiter is a three-state machine. ARB_IDLE means no owner. ARB_LEFT_OWNS and ARB_RIGHT_OWNS mean the left or right side holds the grant. The machine leaves ARB_IDLE for one of the owner states when a collision appears (transition "claim"). It stays in the owner state while the owner keeps its select and address (transition "hold"). It falls back, or re-arbitrates in the same cycle, once the owner finishes (transition "release"). In slave role it is forced to ARB_IDLE (transition "strap").

Top module: `dpa_busy_arbiter`

## Requirements
- R1: In master role, when either side is deselected or the two addresses differ, both BUSY outputs are high.
- R2: In master role, if both sides were selected in the previous cycle and their addresses now match, the side whose address equals its previous-cycle value wins when only one side's address is unchanged; the other side's BUSY goes low in that same cycle.
- R3: In master role, if exactly one side was selected in the previous cycle and a collision now exists, that side wins.
- R4: Any collision that the rules of R2 and R3 cannot order is granted to the left side, so the right BUSY goes low.
- R5: A side whose BUSY is low gets no byte-lane strobes, and its write-block output is high whenever it is selected with write strobe low.
- R6: A grant persists while the owner keeps its select active and its address unchanged and the collision continues. In the cycle where any of these stops, the loser's BUSY returns high.
- R7: After release, the waiting side's pending write produces its byte-lane strobes.
- R8: In slave role, each BUSY output equals the corresponding BUSY input, no arbitration takes place, and a low BUSY input blocks that side's writes.
- R9: Lane strobe bit 1 follows the upper byte enable (data bits 15:8) and bit 0 follows the lower byte enable (data bits 7:0) on a selected, non-busy write.
- R10: A read (write strobe high) never produces lane strobes or a write-block indication.
- R11: While reset is low with both sides deselected, both BUSY outputs are high and all strobes and write-block outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| master_mode | input | 1 | Role strap: 1 arbitrates, 0 follows BUSY inputs |
| l_sel_n | input | 1 | Left select, active low |
| l_wr_n | input | 1 | Left write strobe, active low (high = read) |
| l_ub_n | input | 1 | Left upper byte enable, active low |
| l_lb_n | input | 1 | Left lower byte enable, active low |
| l_addr | input | 13 | Left word address |
| r_sel_n | input | 1 | Right select, active low |
| r_wr_n | input | 1 | Right write strobe, active low |
| r_ub_n | input | 1 | Right upper byte enable, active low |
| r_lb_n | input | 1 | Right lower byte enable, active low |
| r_addr | input | 13 | Right word address |
| l_busy_in_n | input | 1 | Left BUSY from an external master (slave role) |
| r_busy_in_n | input | 1 | Right BUSY from an external master (slave role) |
| l_busy_n | output | 1 | Left BUSY, active low |
| r_busy_n | output | 1 | Right BUSY, active low |
| l_wr_block | output | 1 | Left write is being held off |
| r_wr_block | output | 1 | Right write is being held off |
| l_lane_we | output | 2 | Left byte-lane write strobes {upper, lower} |
| r_lane_we | output | 2 | Right byte-lane write strobes {upper, lower} |

## Verification
Some properties are checked on every cycle. Both BUSY lines stay high when there is no collision. A tie with two freshly selected sides always blocks the right side. A busy side or a read never strobes a lane. A grant survives while its owner is steady. In slave role a low BUSY input kills the strobes and the machine returns to idle. The ordering rules can only be shown by the bench's stimulus sequences: address-arrival order, select-arrival order, release followed by service of the waiting write, and the lane mapping checked through the contents of a behavioural memory.

// File: rtl/dpa_pkg.sv
package dpa_pkg;
    localparam int BYTE_LANES = 2;

    typedef enum logic [1:0] {
        ARB_IDLE       = 2'd0,
        ARB_LEFT_OWNS  = 2'd1,
        ARB_RIGHT_OWNS = 2'd2
    } arb_state_e;

    typedef enum logic [1:0] {
        WIN_NONE  = 2'd0,
        WIN_LEFT  = 2'd1,
        WIN_RIGHT = 2'd2
    } winner_e;
endpackage

// File: rtl/dpa_port_track.sv
module dpa_port_track #(
    parameter int ADDR_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic [ADDR_W-1:0] addr,
    output logic              sel_q,
    output logic              addr_held
);
    logic [ADDR_W-1:0] addr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q  <= 1'b0;
            addr_q <= '0;
        end else begin
            sel_q  <= sel;
            addr_q <= addr;
        end
    end

    assign addr_held = (addr == addr_q);
endmodule

// File: rtl/dpa_arb_fsm.sv
module dpa_arb_fsm
    import dpa_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic master_mode,
    input  logic l_sel,
    input  logic r_sel,
    input  logic conflict,
    input  logic l_sel_q,
    input  logic r_sel_q,
    input  logic l_addr_held,
    input  logic r_addr_held,
    output logic arb_l_busy_n,
    output logic arb_r_busy_n
);
    arb_state_e state_q, state_d;
    winner_e    pick, win;
    logic       left_done, right_done, free;

    // Ordering of a fresh collision: address arrival when both were
    // already selected, select arrival otherwise, ties to the left.
    always_comb begin
        pick = WIN_LEFT;
        if (l_sel_q && r_sel_q) begin
            if (!l_addr_held && r_addr_held) pick = WIN_RIGHT;
        end else if (r_sel_q && !l_sel_q) begin
            pick = WIN_RIGHT;
        end
    end

    assign left_done  = !l_sel || !l_addr_held || !conflict;
    assign right_done = !r_sel || !r_addr_held || !conflict;

    always_comb begin
        unique case (state_q)
            ARB_IDLE:       free = 1'b1;
            ARB_LEFT_OWNS:  free = left_done;
            ARB_RIGHT_OWNS: free = right_done;
            default:        free = 1'b1;
        endcase
        if (!master_mode)  win = WIN_NONE;
        else if (free)     win = conflict ? pick : WIN_NONE;
        else if (state_q == ARB_LEFT_OWNS) win = WIN_LEFT;
        else               win = WIN_RIGHT;
    end

    // Outputs and next state
    always_comb begin
        unique case (win)
            WIN_LEFT:  state_d = ARB_LEFT_OWNS;
            WIN_RIGHT: state_d = ARB_RIGHT_OWNS;
            default:   state_d = ARB_IDLE;
        endcase
        arb_l_busy_n = (win != WIN_RIGHT);
        arb_r_busy_n = (win != WIN_LEFT);
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ARB_IDLE;
        else        state_q <= state_d;
    end

    p_strap_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !master_mode |=> (state_q == ARB_IDLE));
endmodule

// File: rtl/dpa_wr_gate.sv
module dpa_wr_gate #(
    parameter int LANES = 2
) (
    input  logic             sel,
    input  logic             wr,
    input  logic [LANES-1:0] be_n,
    input  logic             busy_n,
    output logic [LANES-1:0] lane_we,
    output logic             blocked
);
    logic go;
    assign go      = sel && wr && busy_n;
    assign blocked = sel && wr && !busy_n;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign lane_we[i] = go && !be_n[i];
    end
endmodule

// File: rtl/dpa_busy_arbiter.sv
module dpa_busy_arbiter
    import dpa_pkg::*;
#(
    parameter int ADDR_W = 13
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  master_mode,
    input  logic                  l_sel_n,
    input  logic                  l_wr_n,
    input  logic                  l_ub_n,
    input  logic                  l_lb_n,
    input  logic [ADDR_W-1:0]     l_addr,
    input  logic                  r_sel_n,
    input  logic                  r_wr_n,
    input  logic                  r_ub_n,
    input  logic                  r_lb_n,
    input  logic [ADDR_W-1:0]     r_addr,
    input  logic                  l_busy_in_n,
    input  logic                  r_busy_in_n,
    output logic                  l_busy_n,
    output logic                  r_busy_n,
    output logic                  l_wr_block,
    output logic                  r_wr_block,
    output logic [BYTE_LANES-1:0] l_lane_we,
    output logic [BYTE_LANES-1:0] r_lane_we
);
    logic l_sel, r_sel, conflict;
    logic l_sel_q, r_sel_q, l_addr_held, r_addr_held;
    logic arb_l_busy_n, arb_r_busy_n;

    assign l_sel    = !l_sel_n;
    assign r_sel    = !r_sel_n;
    assign conflict = l_sel && r_sel && (l_addr == r_addr);

    dpa_port_track #(.ADDR_W(ADDR_W)) u_track_l (
        .clk(clk), .rst_n(rst_n), .sel(l_sel), .addr(l_addr),
        .sel_q(l_sel_q), .addr_held(l_addr_held)
    );
    dpa_port_track #(.ADDR_W(ADDR_W)) u_track_r (
        .clk(clk), .rst_n(rst_n), .sel(r_sel), .addr(r_addr),
        .sel_q(r_sel_q), .addr_held(r_addr_held)
    );

    dpa_arb_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .master_mode(master_mode),
        .l_sel(l_sel), .r_sel(r_sel), .conflict(conflict),
        .l_sel_q(l_sel_q), .r_sel_q(r_sel_q),
        .l_addr_held(l_addr_held), .r_addr_held(r_addr_held),
        .arb_l_busy_n(arb_l_busy_n), .arb_r_busy_n(arb_r_busy_n)
    );

    assign l_busy_n = master_mode ? arb_l_busy_n : l_busy_in_n;
    assign r_busy_n = master_mode ? arb_r_busy_n : r_busy_in_n;

    dpa_wr_gate #(.LANES(BYTE_LANES)) u_gate_l (
        .sel(l_sel), .wr(!l_wr_n), .be_n({l_ub_n, l_lb_n}), .busy_n(l_busy_n),
        .lane_we(l_lane_we), .blocked(l_wr_block)
    );
    dpa_wr_gate #(.LANES(BYTE_LANES)) u_gate_r (
        .sel(r_sel), .wr(!r_wr_n), .be_n({r_ub_n, r_lb_n}), .busy_n(r_busy_n),
        .lane_we(r_lane_we), .blocked(r_wr_block)
    );

    p_apart_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (master_mode && !conflict) |-> (l_busy_n && r_busy_n));

    p_tie_left_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (master_mode && conflict && !l_sel_q && !r_sel_q) |-> (l_busy_n && !r_busy_n));

    p_loser_no_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!l_busy_n || !r_busy_n) |->
            ((l_busy_n || l_lane_we == '0) && (r_busy_n || r_lane_we == '0)));

    p_grant_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (master_mode && !r_busy_n) |=>
            (!(master_mode && conflict && l_addr_held) || !r_busy_n));

    p_slave_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!master_mode && !l_busy_in_n) |-> (l_lane_we == '0));

    p_read_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        l_wr_n |-> (l_lane_we == '0 && !l_wr_block));
endmodule

// File: tb/test_dpa_busy_arbiter.sv
module test_dpa_busy_arbiter;
    localparam int CLK_PERIOD = 10;
    localparam int SEED       = 32'h5eed_0c1a;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        master_mode = 1'b1;
    logic        l_sel_n = 1'b1, l_wr_n = 1'b1, l_ub_n = 1'b1, l_lb_n = 1'b1;
    logic        r_sel_n = 1'b1, r_wr_n = 1'b1, r_ub_n = 1'b1, r_lb_n = 1'b1;
    logic [12:0] l_addr = '0, r_addr = '0;
    logic        l_busy_in_n = 1'b1, r_busy_in_n = 1'b1;
    logic        l_busy_n, r_busy_n, l_wr_block, r_wr_block;
    logic [1:0]  l_lane_we, r_lane_we;
    logic [15:0] l_data = '0, r_data = '0;

    int checks = 0;
    int fails  = 0;

    // bench model of the requirements
    int          m_st = 0;
    logic        m_lsel_q = 1'b0, m_rsel_q = 1'b0;
    logic [12:0] m_la_q = '0, m_ra_q = '0;
    logic [15:0] dut_mem [64];
    logic [15:0] ref_mem [64];

    always #(CLK_PERIOD/2) clk = ~clk;

    dpa_busy_arbiter i_dpa_busy_arbiter (
        .clk(clk), .rst_n(rst_n), .master_mode(master_mode),
        .l_sel_n(l_sel_n), .l_wr_n(l_wr_n), .l_ub_n(l_ub_n), .l_lb_n(l_lb_n), .l_addr(l_addr),
        .r_sel_n(r_sel_n), .r_wr_n(r_wr_n), .r_ub_n(r_ub_n), .r_lb_n(r_lb_n), .r_addr(r_addr),
        .l_busy_in_n(l_busy_in_n), .r_busy_in_n(r_busy_in_n),
        .l_busy_n(l_busy_n), .r_busy_n(r_busy_n),
        .l_wr_block(l_wr_block), .r_wr_block(r_wr_block),
        .l_lane_we(l_lane_we), .r_lane_we(r_lane_we)
    );

    function automatic logic [15:0] merge(input logic [15:0] old, input logic [15:0] d,
                                          input logic [1:0] we);
        return {we[1] ? d[15:8] : old[15:8], we[0] ? d[7:0] : old[7:0]};
    endfunction

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got busy/blk/lanes=%b expected %b at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic setl(input bit s, input bit w, input bit u, input bit lo, input int a);
        l_sel_n = !s; l_wr_n = !w; l_ub_n = !u; l_lb_n = !lo; l_addr = 13'(a);
        l_data = 16'($urandom);
    endtask

    task automatic setr(input bit s, input bit w, input bit u, input bit lo, input int a);
        r_sel_n = !s; r_wr_n = !w; r_ub_n = !u; r_lb_n = !lo; r_addr = 13'(a);
        r_data = 16'($urandom);
    endtask

    // one cycle: check outputs for the current inputs, then advance the model
    task automatic step(input string tag);
        bit lsel, rsel, conf, lh, rh, free, eb_l, eb_r;
        int pick, win;
        logic [1:0] el, er, al, ar;
        #1;
        lsel = !l_sel_n; rsel = !r_sel_n;
        conf = lsel && rsel && (l_addr == r_addr);
        lh = (l_addr == m_la_q); rh = (r_addr == m_ra_q);
        pick = 1;
        if (m_lsel_q && m_rsel_q) begin
            if (!lh && rh) pick = 2;
        end else if (m_rsel_q && !m_lsel_q) pick = 2;
        free = (m_st == 0) || (m_st == 1 && (!lsel || !lh || !conf))
                           || (m_st == 2 && (!rsel || !rh || !conf));
        if (!master_mode)  win = 0;
        else if (free)     win = conf ? pick : 0;
        else               win = m_st;
        if (master_mode) begin eb_l = (win != 2); eb_r = (win != 1); end
        else begin eb_l = l_busy_in_n; eb_r = r_busy_in_n; end
        el = (lsel && !l_wr_n && eb_l) ? {!l_ub_n, !l_lb_n} : 2'b00;
        er = (rsel && !r_wr_n && eb_r) ? {!r_ub_n, !r_lb_n} : 2'b00;
        check(tag, {l_busy_n, r_busy_n, l_wr_block, r_wr_block, l_lane_we, r_lane_we},
                   {eb_l, eb_r, lsel && !l_wr_n && !eb_l, rsel && !r_wr_n && !eb_r, el, er});
        al = l_lane_we; ar = r_lane_we;
        @(posedge clk);
        dut_mem[l_addr[5:0]] = merge(dut_mem[l_addr[5:0]], l_data, al);
        dut_mem[r_addr[5:0]] = merge(dut_mem[r_addr[5:0]], r_data, ar);
        ref_mem[l_addr[5:0]] = merge(ref_mem[l_addr[5:0]], l_data, el);
        ref_mem[r_addr[5:0]] = merge(ref_mem[r_addr[5:0]], r_data, er);
        m_st = win; m_lsel_q = lsel; m_rsel_q = rsel; m_la_q = l_addr; m_ra_q = r_addr;
        @(negedge clk);
    endtask

    task automatic park();
        setl(0, 0, 0, 0, 0); setr(0, 0, 0, 0, 0);
        step("park R1");
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        checks++; fails++;
        $display("FAIL watchdog: got hung run expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(SEED));
        for (int i = 0; i < 64; i++) begin dut_mem[i] = '0; ref_mem[i] = '0; end
        repeat (2) @(negedge clk);
        #1;
        check("R11 reset", {l_busy_n, r_busy_n, l_wr_block, r_wr_block, l_lane_we, r_lane_we},
              8'b1100_0000);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: different addresses, both writing
        setl(1, 1, 1, 1, 5); setr(1, 1, 1, 1, 6); step("R1 distinct addresses");
        setl(1, 1, 1, 1, 5); setr(0, 1, 1, 1, 5); step("R1 right deselected");
        park();

        // R4 tie then R6 hold then release R7
        setl(1, 1, 1, 1, 7); setr(1, 1, 1, 1, 7); step("R4 same-cycle tie");
        step("R6 grant held");
        setl(0, 0, 0, 0, 7); step("R6 owner deselect releases");
        step("R7 waiting write served");
        park();

        // R2 address order, both directions
        setl(1, 1, 1, 1, 8); setr(1, 1, 1, 1, 9); step("R2 setup");
        setr(1, 1, 1, 1, 8); step("R2 left address first");
        park();
        setl(1, 1, 1, 1, 10); setr(1, 1, 1, 1, 11); step("R2 setup");
        setl(1, 1, 1, 1, 11); step("R2 right address first");
        step("R6 right grant held");
        setr(1, 1, 1, 1, 12); step("R6 owner address change releases");
        park();

        // R3 select order, both directions
        setl(1, 1, 1, 1, 12); setr(0, 1, 1, 1, 12); step("R3 setup");
        setr(1, 1, 1, 1, 12); step("R3 left selected first");
        park();
        setr(1, 1, 1, 1, 13); setl(0, 1, 1, 1, 13); step("R3 setup");
        setl(1, 1, 1, 1, 13); step("R3 right selected first");
        setr(0, 0, 0, 0, 13); step("R7 left served after release");
        park();

        // R9 byte lanes
        setl(1, 1, 1, 0, 20); setr(1, 1, 0, 1, 21); step("R9 upper only / lower only");
        setl(1, 1, 0, 1, 22); setr(1, 1, 1, 0, 23); step("R9 lower only / upper only");
        // R10 reads
        setl(1, 0, 1, 1, 24); setr(1, 0, 1, 1, 25); step("R10 reads apart");
        park();
        setl(1, 0, 1, 1, 26); setr(1, 0, 1, 1, 26); step("R10 reads colliding");
        park();

        // R5 loser write blocked while winner reads
        setl(1, 0, 1, 1, 30); setr(1, 1, 1, 1, 30); step("R5 loser write blocked");
        park();

        // R8 slave role
        master_mode = 1'b0;
        l_busy_in_n = 1'b0; r_busy_in_n = 1'b1;
        setl(1, 1, 1, 1, 31); setr(1, 1, 1, 1, 31); step("R8 slave left held off");
        l_busy_in_n = 1'b1; r_busy_in_n = 1'b0; step("R8 slave right held off");
        l_busy_in_n = 1'b1; r_busy_in_n = 1'b1;
        setl(1, 1, 1, 1, 32); setr(1, 1, 1, 1, 33); step("R8 slave no arbitration");
        for (int i = 0; i < 400; i++) begin
            l_busy_in_n = 1'($urandom); r_busy_in_n = 1'($urandom);
            setl($urandom_range(3) != 0, 1'($urandom), 1'($urandom), 1'($urandom), $urandom_range(3));
            setr($urandom_range(3) != 0, 1'($urandom), 1'($urandom), 1'($urandom), $urandom_range(3) + 40);
            step("R8 random slave");
        end
        master_mode = 1'b1; l_busy_in_n = 1'b1; r_busy_in_n = 1'b1;
        park();

        // random master traffic, addresses held over a few cycles
        for (int i = 0; i < 3000; i++) begin
            if ($urandom_range(2) == 0)
                setl($urandom_range(4) != 0, 1'($urandom), 1'($urandom), 1'($urandom), $urandom_range(3));
            if ($urandom_range(2) == 0)
                setr($urandom_range(4) != 0, 1'($urandom), 1'($urandom), 1'($urandom), $urandom_range(3));
            step("R2/R3/R5/R6 random master");
        end
        park();

        checks++;
        begin
            int bad = 0;
            for (int i = 0; i < 64; i++) if (dut_mem[i] !== ref_mem[i]) bad++;
            if (bad != 0) begin
                fails++;
                $display("FAIL R9 memory image: got %0d mismatching words expected 0", bad);
            end
        end
        finish_run();
    end
endmodule